// File: doc/BRIEF.md
# Fractional Signed Multiply Unit

This block is the multiply datapath of a 16-bit fixed-point signal processor. It takes two signed fractional operands and forms their product. Because both operands carry one sign bit and fifteen fraction bits, the raw two's-complement product is doubled so that the binary point of the result lines up with the accumulator format.

A strobe `go` starts an operation, and `dst_reg` picks the destination. When `dst_reg` is low, the product is written to a 36-bit accumulator: four extension bits, then an upper word and a lower word. When `dst_reg` is high, only the upper sixteen bits of the fractional product are written, to a separate 16-bit register. Every operation also updates five status flags: extension in use, unnormalized, negative, zero and overflow.

The result appears one clock edge after the strobe. The destination that was not selected keeps its value.

Top module: `frac_mul_unit`

## Requirements
- R1: On an operation, the 36-bit result is twice the signed product of `src_a` and `src_b`, sign-extended to 36 bits. For example, 0x02A0 times 0x0200 gives 0x0_000A_8000.
- R2: The outputs change only at the rising clock edge where `go` is sampled high. A value is visible right after that edge.
- R3: With `dst_reg` = 0, `acc_q` receives the full 36-bit result. Bits 35..32 carry the sign extension, and 0x8000 times 0x8000 gives +1.0, which is 0x0_8000_0000.
- R4: With `dst_reg` = 1, `reg_q` receives bits 31..16 of the result, with no rounding and no limiting. For example, 0x8000 times 0x8000 gives 0x8000.
- R5: The destination that is not selected keeps its value. The prior contents of the selected destination have no effect on the new value.
- R6: `flag_n` equals bit 35 of the 36-bit result.
- R7: `flag_z` is 1 exactly when all 36 bits of the result are zero.
- R8: `flag_v` is 0 after every operation.
- R9: `flag_e` is 1 when bits 35..31 of the result are not all equal.
- R10: `flag_u` is 1 when bit 31 equals bit 30 of the result.
- R11: The flags describe the full 36-bit result in both destination modes.
- R12: Reset (`rst_n` low) clears all outputs to zero. While `go` is low, every output holds its value, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Starts an operation on this edge |
| dst_reg | input | 1 | 0: write the accumulator; 1: write the 16-bit register |
| src_a | input | 16 | Signed fractional operand |
| src_b | input | 16 | Signed fractional operand |
| acc_q | output | 36 | Accumulator result |
| reg_q | output | 16 | 16-bit register result |
| flag_e | output | 1 | Extension bits in use |
| flag_u | output | 1 | Result unnormalized |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_v | output | 1 | Overflow, always cleared |

## Verification
The assertions assume that `go`, `dst_reg` and both operands are known and stable around every rising edge once reset is released. They also assume that the hold properties apply only in cycles where `go` is low. The bench changes every input on the falling edge and gives each input a defined value from time zero. It also changes the operands while `go` is low, so that the hold behaviour is actually exercised rather than met trivially.

// File: rtl/frac_mul_unit.sv
module frac_mul_unit #(
  parameter  int OP_W  = 16,
  parameter  int EXT_W = 4,
  localparam int PR_W  = 2 * OP_W,
  localparam int ACC_W = EXT_W + PR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             dst_reg,
  input  logic [OP_W-1:0]  src_a,
  input  logic [OP_W-1:0]  src_b,
  output logic [ACC_W-1:0] acc_q,
  output logic [OP_W-1:0]  reg_q,
  output logic             flag_e,
  output logic             flag_u,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v
);

  localparam logic [OP_W-1:0] MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};

  logic signed [PR_W-1:0] prod;
  logic [ACC_W-1:0]       res;
  logic [EXT_W:0]         top;

  assign prod = $signed(src_a) * $signed(src_b);
  assign res  = {{(EXT_W-1){prod[PR_W-1]}}, prod, 1'b0};
  assign top  = res[ACC_W-1:PR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      reg_q  <= '0;
      flag_e <= 1'b0;
      flag_u <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
    end else if (go) begin
      if (dst_reg) reg_q <= res[PR_W-1:OP_W];
      else         acc_q <= res;
      flag_e <= !((&top) || !(|top));
      flag_u <= res[PR_W-1] == res[PR_W-2];
      flag_n <= res[ACC_W-1];
      flag_z <= res == '0;
      flag_v <= 1'b0;
    end
  end

  a_r5_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    go && dst_reg |=> $stable(acc_q));

  a_r5_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    go && !dst_reg |=> $stable(reg_q));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(acc_q) && $stable(reg_q) && $stable({flag_e, flag_u, flag_n, flag_z, flag_v}));

  a_r1_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    go && !dst_reg |=> acc_q[0] == 1'b0);

  a_r3_sign: assert property (@(posedge clk) disable iff (!rst_n)
    go && !dst_reg |=> acc_q[ACC_W-1] == ($past(src_a[OP_W-1]) ^ $past(src_b[OP_W-1]))
                       || acc_q == '0
                       || ($past(src_a) == MOST_NEG && $past(src_b) == MOST_NEG));

  a_r7_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    go && (src_a == '0 || src_b == '0) |=> flag_z && !flag_n && !flag_e);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(go) |-> !flag_v);

  a_r9_e_only_at_min: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> flag_e == ($past(src_a) == MOST_NEG && $past(src_b) == MOST_NEG));

endmodule

// File: tb/tb_frac_mul_unit.sv
module tb_frac_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic        dst_reg = 1'b0;
  logic [15:0] src_a = '0;
  logic [15:0] src_b = '0;
  logic [35:0] acc_q;
  logic [15:0] reg_q;
  logic        flag_e, flag_u, flag_n, flag_z, flag_v;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  frac_mul_unit dut (
    .clk(clk), .rst_n(rst_n), .go(go), .dst_reg(dst_reg),
    .src_a(src_a), .src_b(src_b), .acc_q(acc_q), .reg_q(reg_q),
    .flag_e(flag_e), .flag_u(flag_u), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
  );

  // {dst_reg, a, b}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h02A0, 16'h0200},
    {1'b0, 16'h8000, 16'h8000},
    {1'b1, 16'h8000, 16'h8000},
    {1'b0, 16'h8000, 16'h7FFF},
    {1'b1, 16'h7FFF, 16'h7FFF},
    {1'b0, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'h0000, 16'h1234},
    {1'b1, 16'hFFFF, 16'h0001},
    {1'b0, 16'h4000, 16'h4000},
    {1'b0, 16'hC000, 16'h4000},
    {1'b1, 16'h1234, 16'hEDCC},
    {1'b0, 16'h0001, 16'h0001}
  };

  function automatic logic [35:0] model(input logic [15:0] a, input logic [15:0] b);
    longint p;
    p = 2 * longint'($signed(a)) * longint'($signed(b));
    return p[35:0];
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_flags(input logic [35:0] r);
    chk("R6 negative", flag_n, r[35]);
    chk("R7 zero", flag_z, r == '0);
    chk("R8 overflow", flag_v, 1'b0);
    chk("R9 extension", flag_e, !((&r[35:31]) || !(|r[35:31])));
    chk("R10 unnormalized", flag_u, r[31] == r[30]);
  endtask

  task automatic op(input logic d, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    go = 1'b1; dst_reg = d; src_a = a; src_b = b;
    @(negedge clk);
    go = 1'b0; src_a = ~a; src_b = b ^ 16'h5A5A;
  endtask

  initial begin
    fork
      begin
        logic [35:0] acc_exp;
        logic [15:0] reg_exp;
        logic [35:0] r;
        repeat (3) @(negedge clk);
        chk("R12 reset acc", acc_q, 36'h0);
        chk("R12 reset reg", reg_q, 16'h0);
        chk("R12 reset flags", {flag_e, flag_u, flag_n, flag_z, flag_v}, 5'b0);
        rst_n = 1'b1;
        acc_exp = '0; reg_exp = '0;

        for (int i = 0; i < NV; i++) begin
          op(VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
          r = model(VEC[i][31:16], VEC[i][15:0]);
          if (VEC[i][32]) reg_exp = r[31:16];
          else            acc_exp = r;
          chk(VEC[i][32] ? "R4 register value" : "R3 accumulator value", VEC[i][32] ? reg_q : acc_q,
              VEC[i][32] ? reg_exp : acc_exp);
          chk("R5 other destination kept", VEC[i][32] ? acc_q : reg_q, VEC[i][32] ? acc_exp : reg_exp);
          check_flags(r);  // R11 flags from the full result in both modes
        end

        op(1'b0, 16'h02A0, 16'h0200);
        chk("R1 example product", acc_q, 36'h0_000A_8000);
        op(1'b0, 16'h8000, 16'h8000);
        chk("R3 plus one", acc_q, 36'h0_8000_0000);
        chk("R9 extension at plus one", flag_e, 1'b1);
        op(1'b1, 16'h8000, 16'h8000);
        chk("R4 no limiting", reg_q, 16'h8000);
        chk("R11 flags in register mode", {flag_e, flag_n, flag_z}, 3'b100);

        @(negedge clk);
        dst_reg = 1'b1; src_a = 16'h7777; src_b = 16'h3333;
        repeat (3) @(negedge clk);
        chk("R12 idle acc hold", acc_q, 36'h0_8000_0000);
        chk("R12 idle reg hold", reg_q, 16'h8000);
        chk("R12 idle flag hold", flag_e, 1'b1);

        @(negedge clk);
        go = 1'b1; dst_reg = 1'b0; src_a = 16'h0100; src_b = 16'h0100;
        @(posedge clk);
        #1;
        chk("R2 one edge latency", acc_q, 36'h0_0002_0000);
        @(negedge clk);
        go = 1'b0;

        op(1'b0, 16'h0000, 16'h8000);
        chk("R5 prior contents irrelevant", acc_q, 36'h0);
        chk("R7 zero result", flag_z, 1'b1);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule